// File: doc/BRIEF.md
# Converter Sample Buffer with Half-Capacity Interrupt

This block stores 12-bit conversion results between an analog converter and a host register interface. The converter side offers each result as a valid/ready beat. The converter cannot be stalled, so a beat offered while the buffer is full is lost and recorded in a sticky overflow bit. The host removes results through a valid/ready read port. Each result comes back as a 16-bit word that carries the sample in its low twelve bits and zeros in the upper four.

Three status flags are active-low: empty, more-than-half-full, and full. When the occupancy first rises past half of capacity, an interrupt is latched. It stays raised until the host writes the flag-clear strobe. A separate contents-clear strobe discards every stored sample and leaves the interrupt and overflow state untouched. The flag-clear strobe returns both the interrupt and overflow state to their reset values and does not touch the stored samples.

Back-pressure rules: `in_ready` equals `full_n`. A beat is stored only on a cycle where `in_valid` and `in_ready` are both high. `rd_valid` equals `empty_n`. A pop happens on a cycle where `rd_valid` and `rd_ready` are both high. `rd_ready` may be raised while `rd_valid` is low, and this has no effect.

Top module: `sample_fifo_hf`

## Requirements
- R1: After reset: `empty_n`=0, `half_n`=1, `full_n`=1, `irq`=0, `overflow`=0, `in_ready`=1, `rd_valid`=0 and `rd_word`=0.
- R2: Samples leave in the order they entered. `rd_word[11:0]` holds the popped sample and `rd_word[15:12]` is 0. The word appears on the clock edge after the pop handshake.
- R3: `empty_n` is 0 exactly when the occupancy is 0, and `rd_valid` follows `empty_n`.
- R4: `half_n` is 0 exactly when the occupancy exceeds DEPTH/2 (513 or more of 1024).
- R5: `full_n` is 0 exactly when the occupancy equals DEPTH, and `in_ready` follows `full_n`.
- R6: A beat offered while full is not stored and sets `overflow`. `overflow` stays set until a flag clear.
- R7: `rd_ready` while empty leaves `rd_word` and the occupancy unchanged.
- R8: `irq` rises one cycle after the occupancy first exceeds DEPTH/2. It holds until a flag clear. An occupancy that stays above half does not raise it again.
- R9: A one-cycle `clr_flag` pulse makes `irq` and `overflow` 0 after the edge. If a new half-capacity crossing lands on that same edge, the crossing wins.
- R10: A one-cycle `clr_fifo` pulse makes the buffer empty after the edge. It overrides a push or pop on the same cycle and leaves `irq` and `overflow` as they were.
- R11: A push and a pop on the same cycle, with the buffer neither empty nor full, leave the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Converter result offered |
| in_ready | output | 1 | Buffer can take a result (equals full_n) |
| in_code | input | 12 | Converter result |
| rd_valid | output | 1 | A sample is available (equals empty_n) |
| rd_ready | input | 1 | Host pops one sample |
| rd_word | output | 16 | Last popped sample, zero-extended |
| clr_fifo | input | 1 | Discard all stored samples |
| clr_flag | input | 1 | Clear interrupt and overflow |
| empty_n | output | 1 | Low when empty |
| half_n | output | 1 | Low when more than half full |
| full_n | output | 1 | Low when full |
| irq | output | 1 | Latched half-capacity interrupt |
| overflow | output | 1 | Sticky dropped-result indicator |

## Verification
The flags change on the same edge that changes the occupancy. `rd_word` changes on the edge that completes the pop. `irq` follows the occupancy one edge later, because it is compared against a registered copy of the half condition. The bench drives inputs at falling edges and samples at the next falling edge for the flags and the read word. For the interrupt it inserts one extra idle cycle. It checks `irq` both before and after that cycle, so an interrupt that arrives a cycle early or a cycle late is reported.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  localparam int CODE_W  = 12;
  localparam int WORD_W  = 16;
  localparam int DEPTH   = 1024;
endpackage

// File: rtl/sfifo_ptrs.sv
module sfifo_ptrs #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic          clr,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] occ
);
  // DEPTH is a power of two, so the pointers wrap naturally
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else if (clr) begin
      wptr <= '0;
      rptr <= '0;
      occ  <= '0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      unique case ({push, pop})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: occ <= occ;
      endcase
    end
  end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DEPTH  = 1024,
  parameter int CODE_W = 12,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [CODE_W-1:0] rdata_q
);
  logic [CODE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read register holds the last popped value between pops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (re) rdata_q <= mem[raddr];
  end
endmodule

// File: rtl/sfifo_flags.sv
module sfifo_flags #(
  parameter int DEPTH = 1024,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occ,
  input  logic          ovf_evt,
  input  logic          clr_flag,
  output logic          empty_n,
  output logic          half_n,
  output logic          full_n,
  output logic          irq,
  output logic          overflow
);
  localparam logic [CW-1:0] HALF_OCC = CW'(DEPTH / 2);
  localparam logic [CW-1:0] FULL_OCC = CW'(DEPTH);

  logic above_half;
  logic above_half_q;
  logic crossing;

  assign above_half = (occ > HALF_OCC);
  assign crossing   = above_half & ~above_half_q;

  assign empty_n = (occ != '0);
  assign half_n  = ~above_half;
  assign full_n  = (occ != FULL_OCC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      above_half_q <= 1'b0;
      irq          <= 1'b0;
      overflow     <= 1'b0;
    end else begin
      above_half_q <= above_half;
      irq          <= (irq & ~clr_flag) | crossing;
      overflow     <= (overflow & ~clr_flag) | ovf_evt;
    end
  end
endmodule

// File: rtl/sample_fifo_hf.sv
module sample_fifo_hf
  import sfifo_pkg::*;
#(
  parameter int DEPTH_P  = DEPTH,
  parameter int CODE_WP  = CODE_W,
  parameter int WORD_WP  = WORD_W,
  localparam int AW = $clog2(DEPTH_P),
  localparam int CW = $clog2(DEPTH_P + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CODE_WP-1:0] in_code,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [WORD_WP-1:0] rd_word,
  input  logic               clr_fifo,
  input  logic               clr_flag,
  output logic               empty_n,
  output logic               half_n,
  output logic               full_n,
  output logic               irq,
  output logic               overflow
);
  logic [AW-1:0]      wptr;
  logic [AW-1:0]      rptr;
  logic [CW-1:0]      occ;
  logic               push_ok;
  logic               pop_ok;
  logic               ovf_evt;
  logic [CODE_WP-1:0] rdata_q;

  assign in_ready = full_n;
  assign rd_valid = empty_n;
  assign push_ok  = in_valid & in_ready & ~clr_fifo;
  assign pop_ok   = rd_valid & rd_ready & ~clr_fifo;
  assign ovf_evt  = in_valid & ~in_ready;

  sfifo_ptrs #(.DEPTH(DEPTH_P)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_ok), .clr(clr_fifo),
    .wptr(wptr), .rptr(rptr), .occ(occ)
  );

  sfifo_store #(.DEPTH(DEPTH_P), .CODE_W(CODE_WP)) u_store (
    .clk(clk), .rst_n(rst_n), .we(push_ok), .waddr(wptr), .wdata(in_code),
    .re(pop_ok), .raddr(rptr), .rdata_q(rdata_q)
  );

  sfifo_flags #(.DEPTH(DEPTH_P)) u_flags (
    .clk(clk), .rst_n(rst_n), .occ(occ), .ovf_evt(ovf_evt), .clr_flag(clr_flag),
    .empty_n(empty_n), .half_n(half_n), .full_n(full_n), .irq(irq),
    .overflow(overflow)
  );

  generate
    if (WORD_WP > CODE_WP) begin : g_pad
      assign rd_word = {{(WORD_WP - CODE_WP){1'b0}}, rdata_q};
    end else begin : g_nopad
      assign rd_word = rdata_q[WORD_WP-1:0];
    end
  endgenerate
endmodule

// File: rtl/sfifo_chk.sv
module sfifo_chk #(
  parameter int WORD_WP = 16,
  parameter int CW = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic [WORD_WP-1:0] rd_word,
  input logic               clr_fifo,
  input logic               clr_flag,
  input logic               empty_n,
  input logic               half_n,
  input logic               full_n,
  input logic               irq,
  input logic               overflow,
  input logic [CW-1:0]      occ
);
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !full_n |-> !in_ready); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !full_n |=> overflow); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clr_flag |=> overflow); // R6
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ready && !rd_valid && !clr_fifo |=> $stable(rd_word) && $stable(occ)); // R7
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr_flag |=> irq); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !$past(half_n)); // R8
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fifo |=> !empty_n && full_n); // R10
  AST_PUSHPOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && rd_valid && rd_ready && !clr_fifo |=> $stable(occ)); // R11
endmodule

bind sample_fifo_hf sfifo_chk #(.WORD_WP(WORD_WP), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_word(rd_word),
  .clr_fifo(clr_fifo), .clr_flag(clr_flag), .empty_n(empty_n),
  .half_n(half_n), .full_n(full_n), .irq(irq), .overflow(overflow), .occ(occ)
);

// File: tb/sample_fifo_hf_bench.sv
module sample_fifo_hf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // [27:16] code pushed, [15:0] word expected on the matching pop
  localparam logic [27:0] TBL [NVEC] = '{
    {12'h000, 16'h0000}, {12'hFFF, 16'h0FFF}, {12'h800, 16'h0800},
    {12'h7FF, 16'h07FF}, {12'hA5A, 16'h0A5A}, {12'h5A5, 16'h05A5},
    {12'h001, 16'h0001}, {12'h3C3, 16'h03C3}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_code = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [15:0] rd_word;
  logic        clr_fifo = 1'b0;
  logic        clr_flag = 1'b0;
  logic        empty_n, half_n, full_n, irq, overflow;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sample_fifo_hf u_sample_fifo_hf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_word(rd_word), .clr_fifo(clr_fifo), .clr_flag(clr_flag),
    .empty_n(empty_n), .half_n(half_n), .full_n(full_n), .irq(irq),
    .overflow(overflow)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push_n(input int n, input logic [11:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_code  = 12'(base + 12'(i));
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop1();
    @(negedge clk);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic pulse_clr_flag();
    @(negedge clk); clr_flag = 1'b1;
    @(negedge clk); clr_flag = 1'b0;
  endtask

  task automatic pulse_clr_fifo();
    @(negedge clk); clr_fifo = 1'b1;
    @(negedge clk); clr_fifo = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty_n", 32'(empty_n), 0);
    check("R1 half_n", 32'(half_n), 1);
    check("R1 full_n", 32'(full_n), 1);
    check("R1 irq", 32'(irq), 0);
    check("R1 overflow", 32'(overflow), 0);
    check("R1 in_ready", 32'(in_ready), 1);
    check("R1 rd_valid", 32'(rd_valid), 0);
    check("R1 rd_word", 32'(rd_word), 0);

    // table walk: push all, then pop and compare in order (R2)
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_code  = TBL[i][27:16];
    end
    @(negedge clk);
    in_valid = 1'b0;
    check("R3 empty_n after pushes", 32'(empty_n), 1);
    check("R3 rd_valid after pushes", 32'(rd_valid), 1);
    for (int i = 0; i < NVEC; i++) begin
      pop1();
      check("R2 pop order/word", 32'(rd_word), 32'(TBL[i][15:0]));
    end
    check("R3 empty_n after drain", 32'(empty_n), 0);

    // R7 pop while empty
    pop1();
    check("R7 word held on empty pop", 32'(rd_word), 32'(TBL[NVEC-1][15:0]));
    check("R7 still empty", 32'(empty_n), 0);

    // R4/R8 half crossing
    push_n(512, 12'h100);
    @(negedge clk);
    check("R4 half_n at 512", 32'(half_n), 1);
    check("R8 irq at 512", 32'(irq), 0);
    push_n(1, 12'h300);
    check("R4 half_n at 513", 32'(half_n), 0);
    check("R8 irq not yet", 32'(irq), 0);
    @(negedge clk);
    check("R8 irq one cycle later", 32'(irq), 1);

    // R9 clear flag, R8 no re-fire while level held
    pulse_clr_flag();
    check("R9 irq cleared", 32'(irq), 0);
    repeat (3) @(negedge clk);
    check("R8 no re-fire", 32'(irq), 0);

    // R5 fill up, R6 overflow
    push_n(511, 12'h400);
    check("R5 full_n at full", 32'(full_n), 0);
    check("R5 in_ready at full", 32'(in_ready), 0);
    check("R6 overflow before", 32'(overflow), 0);
    push_n(1, 12'hABC);
    check("R6 overflow set", 32'(overflow), 1);
    check("R6 still full", 32'(full_n), 0);
    repeat (2) @(negedge clk);
    check("R6 overflow sticky", 32'(overflow), 1);

    // R11 simultaneous push and pop
    pop1();
    check("R2 first of fill", 32'(rd_word), 32'h100);
    check("R5 full_n after pop", 32'(full_n), 1);
    @(negedge clk);
    in_valid = 1'b1; in_code = 12'h555; rd_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rd_ready = 1'b0;
    check("R11 word from same-cycle pop", 32'(rd_word), 32'h101);
    check("R11 count kept (not full)", 32'(full_n), 1);
    push_n(1, 12'h666);
    check("R11 one push fills", 32'(full_n), 0);

    // R10 clear contents keeps overflow
    pulse_clr_fifo();
    check("R10 empty after clear", 32'(empty_n), 0);
    check("R10 half_n after clear", 32'(half_n), 1);
    check("R10 full_n after clear", 32'(full_n), 1);
    check("R10 overflow kept", 32'(overflow), 1);
    push_n(513, 12'h000);
    @(negedge clk);
    check("R8 irq on new crossing", 32'(irq), 1);
    pulse_clr_fifo();
    check("R10 irq kept over clear", 32'(irq), 1);
    check("R10 empty again", 32'(empty_n), 0);
    push_n(1, 12'h777);
    pop1();
    check("R10 fresh contents", 32'(rd_word), 32'h777);

    // R9 clear flag resets irq and overflow
    pulse_clr_flag();
    check("R9 irq after clr_flag", 32'(irq), 0);
    check("R9 overflow after clr_flag", 32'(overflow), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule